// File: doc/BRIEF.md
# SPI Master with Transmit and Receive Queues

This block is a byte-wide SPI master that a host drives through a small register port. The host pushes outgoing bytes into an 8-entry transmit queue. A shifter takes each queued byte and exchanges it with the slave, most significant bit first and full duplex. The byte captured in the same exchange lands in an 8-entry receive queue, and the host pops it from there. The serial clock comes from a programmable divider of the system clock. Its idle level and its sampling phase can be configured.

The controller has two states only: idle and working. Each working pass shifts one byte and then holds the serial clock at its idle level for one full serial-clock period. After that it either loads the next queued byte or returns to idle. Because of this fixed gap, all four clock modes can run on the same simple controller. Chip select stays low from the first byte until the queue has drained. Every finished byte sets a sticky completion flag, which can raise an interrupt. A write into a full transmit queue is discarded and sets a sticky collision flag.

Top module: `spi_master_fifo`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, irq is 0, and the status register (address 1) reads 0x00A. Status bits are: bit0 transmit queue full, bit1 transmit queue empty, bit2 receive queue full, bit3 receive queue empty, bit4 busy, bit5 completion flag, bit6 collision flag.
- R2: A byte written to address 0 is shifted out on mosi, most significant bit first. The 8 bits shifted in on miso during the same exchange can then be read from address 0, and that read pops the receive queue.
- R3: Configuration lives at address 2. Bits 7:0 hold the divider N, bit8 the polarity, bit9 the phase, and bit10 the interrupt enable. While no byte is in flight, sclk rests at the polarity level: 0 gives a low idle and 1 gives a high idle.
- R4: With phase 0, miso is sampled on the leading sclk edge of each bit, mosi changes on the trailing edge, and the first bit is valid as soon as cs_n falls. With phase 1, mosi changes on the leading edge and miso is sampled on the trailing edge.
- R5: Each sclk half-period lasts N+1 system clocks. The first sclk edge comes N+1 clocks after cs_n falls.
- R6: When bytes are queued back to back, sclk stays at its idle level for one full period between them. The gap from the last edge of one byte to the first edge of the next is 3*(N+1) clocks, and cs_n stays low across it.
- R7: cs_n rises only after a byte has finished and the transmit queue is empty. sclk leaves the idle level only while cs_n is low.
- R8: The transmit queue holds 8 bytes. A data write while it is full is dropped and sets the collision flag. The flag stays set until the host writes 1 to status bit6.
- R9: The receive queue holds 8 bytes and returns them in arrival order. A captured byte that arrives while the queue is full is discarded.
- R10: The completion flag sets at the end of every byte and is cleared by writing 1 to status bit5. irq is high exactly when the completion flag and the interrupt enable are both set.
- R11: A configuration write made while a byte is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 2 | Register select: 0 data, 1 status, 2 configuration |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 11 | Register write value |
| rd_en | input | 1 | Register read strobe (pops the receive queue at address 0) |
| rd_data | output | 11 | Register read value, combinational from addr |
| irq | output | 1 | Completion interrupt |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Slave select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Some properties are checked on every cycle. sclk must hold the polarity level while the slave is deselected, and it may not start toggling while cs_n is high. cs_n may rise only after the transmit queue has emptied. A write into a full queue must raise the collision flag, and that flag must hold until it is cleared. The configuration must not change while a transfer runs. Other behaviour can only be shown by the bench's scenarios, using a slave model that follows each clock mode. These are the bit order and the data actually exchanged, the divider's edge spacing, the length of the inter-byte gap, and queue overflow, ordering and drop behaviour.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

    localparam int DIV_W  = 8;
    localparam int HOST_W = DIV_W + 3;

    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_CFG  = 2'd2;

    localparam int S_TXFULL  = 0;
    localparam int S_TXEMPTY = 1;
    localparam int S_RXFULL  = 2;
    localparam int S_RXEMPTY = 3;
    localparam int S_BUSY    = 4;
    localparam int S_DONE    = 5;
    localparam int S_COLL    = 6;

    localparam int C_CPOL  = DIV_W;
    localparam int C_CPHA  = DIV_W + 1;
    localparam int C_IRQEN = DIV_W + 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WORK = 1'b1
    } eng_st_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             cpol;
        logic             cpha;
        logic             irq_en;
        logic             done;
        logic             coll;
    } regs_t;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t        f_d, f_q;
    logic [W-1:0] mem_q [DEPTH];
    logic         do_push, do_pop;

    assign full    = (f_q.cnt == CW'(DEPTH));
    assign empty   = (f_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem_q[f_q.rp];

    always_comb begin
        f_d = f_q;
        if (do_push) begin
            f_d.wp = (f_q.wp == AW'(DEPTH - 1)) ? '0 : f_q.wp + 1'b1;
        end
        if (do_pop) begin
            f_d.rp = (f_q.rp == AW'(DEPTH - 1)) ? '0 : f_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[f_q.wp] <= wdata;
        end
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_master_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [DIV_W-1:0] div,
    input  logic             tx_valid,
    input  logic [BITS-1:0]  tx_data,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [BITS-1:0]  rx_data,
    output logic             busy,
    output logic             sclk,
    output logic             mosi,
    output logic             cs_n,
    input  logic             miso
);
    localparam int EDGES = 2 * BITS;
    localparam int LAST  = EDGES + 1;
    localparam int EW    = $clog2(LAST + 1);

    typedef struct packed {
        eng_st_e          st;
        logic [DIV_W-1:0] cnt;
        logic [EW-1:0]    edg;
        logic [BITS-1:0]  sh;
        logic             samp;
        logic             sclk;
        logic             cs_n;
    } eng_t;

    eng_t e_d, e_q;
    logic tick, lead, sample_now;

    assign tick       = (e_q.cnt == div);
    assign lead       = ~e_q.edg[0];
    assign sample_now = cpha ? ~lead : lead;

    assign rx_data = cpha ? {e_q.sh[BITS-2:0], e_q.samp} : e_q.sh;
    assign busy    = (e_q.st == ST_WORK);
    assign sclk    = e_q.sclk;
    assign mosi    = e_q.sh[BITS-1];
    assign cs_n    = e_q.cs_n;

    always_comb begin
        e_d     = e_q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        case (e_q.st)
            ST_IDLE: begin
                e_d.sclk = cpol;
                e_d.cnt  = '0;
                e_d.edg  = '0;
                if (tx_valid) begin
                    tx_pop   = 1'b1;
                    e_d.sh   = tx_data;
                    e_d.cs_n = 1'b0;
                    e_d.st   = ST_WORK;
                end
            end
            ST_WORK: begin
                if (!tick) begin
                    e_d.cnt = e_q.cnt + 1'b1;
                end else begin
                    e_d.cnt = '0;
                    e_d.edg = e_q.edg + 1'b1;
                    if (e_q.edg < EW'(EDGES)) begin
                        e_d.sclk = ~e_q.sclk;
                        if (sample_now) begin
                            e_d.samp = miso;
                        end else if (!(cpha && e_q.edg == '0)) begin
                            e_d.sh = {e_q.sh[BITS-2:0], e_q.samp};
                        end
                    end
                    if (e_q.edg == EW'(LAST)) begin
                        rx_push = 1'b1;
                        e_d.edg = '0;
                        if (tx_valid) begin
                            tx_pop = 1'b1;
                            e_d.sh = tx_data;
                        end else begin
                            e_d.st   = ST_IDLE;
                            e_d.cs_n = 1'b1;
                        end
                    end
                end
            end
            default: e_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q      <= '0;
            e_q.st   <= ST_IDLE;
            e_q.cs_n <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

endmodule

// File: rtl/spi_master_fifo.sv
module spi_master_fifo
    import spi_master_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int BITS       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic [HOST_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [HOST_W-1:0] rd_data,
    output logic              irq,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    regs_t             r_d, r_q;
    logic              tx_push, tx_pop, tx_full, tx_empty;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [BITS-1:0]   tx_head, rx_head, rx_byte;
    logic              eng_busy;
    logic [HOST_W-1:0] cfg_word, stat_word;

    spi_byte_fifo #(.W(BITS), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .wdata (wr_data[BITS-1:0]),
        .pop   (tx_pop),
        .rdata (tx_head),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_byte_fifo #(.W(BITS), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_byte),
        .pop   (rx_pop),
        .rdata (rx_head),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spi_shift_engine #(.BITS(BITS)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpol     (r_q.cpol),
        .cpha     (r_q.cpha),
        .div      (r_q.div),
        .tx_valid (!tx_empty),
        .tx_data  (tx_head),
        .tx_pop   (tx_pop),
        .rx_push  (rx_push),
        .rx_data  (rx_byte),
        .busy     (eng_busy),
        .sclk     (sclk),
        .mosi     (mosi),
        .cs_n     (cs_n),
        .miso     (miso)
    );

    always_comb begin
        cfg_word          = '0;
        cfg_word[DIV_W-1:0] = r_q.div;
        cfg_word[C_CPOL]  = r_q.cpol;
        cfg_word[C_CPHA]  = r_q.cpha;
        cfg_word[C_IRQEN] = r_q.irq_en;

        stat_word            = '0;
        stat_word[S_TXFULL]  = tx_full;
        stat_word[S_TXEMPTY] = tx_empty;
        stat_word[S_RXFULL]  = rx_full;
        stat_word[S_RXEMPTY] = rx_empty;
        stat_word[S_BUSY]    = eng_busy;
        stat_word[S_DONE]    = r_q.done;
        stat_word[S_COLL]    = r_q.coll;
    end

    always_comb begin
        r_d     = r_q;
        tx_push = 1'b0;
        if (wr_en) begin
            case (addr)
                A_DATA: begin
                    if (tx_full) r_d.coll = 1'b1;
                    else         tx_push  = 1'b1;
                end
                A_STAT: begin
                    if (wr_data[S_DONE]) r_d.done = 1'b0;
                    if (wr_data[S_COLL]) r_d.coll = 1'b0;
                end
                A_CFG: begin
                    if (!eng_busy) begin
                        r_d.div    = wr_data[DIV_W-1:0];
                        r_d.cpol   = wr_data[C_CPOL];
                        r_d.cpha   = wr_data[C_CPHA];
                        r_d.irq_en = wr_data[C_IRQEN];
                    end
                end
                default: ;
            endcase
        end
        if (rx_push) begin
            r_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_pop = rd_en && (addr == A_DATA) && !rx_empty;
    assign irq    = r_q.done && r_q.irq_en;

    always_comb begin
        case (addr)
            A_DATA:  rd_data = HOST_W'(rx_head);
            A_STAT:  rd_data = stat_word;
            A_CFG:   rd_data = cfg_word;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/spi_master_checker.sv
module spi_master_checker
    import spi_master_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        addr,
    input logic              wr_en,
    input logic              wr_coll_bit,
    input logic              cs_n,
    input logic              sclk,
    input logic              cpol,
    input logic              busy,
    input logic [HOST_W-1:0] cfg_word,
    input logic              tx_full,
    input logic              tx_empty,
    input logic              coll
);

    AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $stable(cpol)) |-> (sclk == cpol)); // R3

    AST_SCLK_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sclk) && $past(cs_n)) |-> (sclk == cpol)); // R7

    AST_CS_RELEASE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $past(tx_empty)); // R7

    AST_FULL_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DATA && tx_full) |=> coll); // R8

    AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (coll && !(wr_en && addr == A_STAT && wr_coll_bit)) |=> coll); // R8

    AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_word)); // R11

endmodule

bind spi_master_fifo spi_master_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .wr_coll_bit (wr_data[spi_master_pkg::S_COLL]),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .cpol        (r_q.cpol),
    .busy        (eng_busy),
    .cfg_word    (cfg_word),
    .tx_full     (tx_full),
    .tx_empty    (tx_empty),
    .coll        (r_q.coll)
);

// File: tb/tb_spi_master_fifo.sv
`timescale 1ns/1ps
module tb_spi_master_fifo;
    import spi_master_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        addr = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [HOST_W-1:0] wr_data = '0;
    logic [HOST_W-1:0] rd_data;
    logic              irq, sclk, cs_n, mosi, miso;

    always #4 clk = ~clk;

    spi_master_fifo dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .irq(irq), .sclk(sclk), .cs_n(cs_n),
        .mosi(mosi), .miso(miso)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(negedge clk) cyc++;

    // slave model (mode set by bench)
    logic       m_cpol = 1'b0, m_cpha = 1'b0;
    logic [7:0] s_sh = 8'h00;
    logic       s_in = 1'b0;
    bit         s_started = 1'b0;
    int         s_cnt = 0;
    logic [7:0] resp_mem [16];
    logic [7:0] got [16];
    int         got_n = 0;
    int         edge_t [64];
    int         edge_n = 0;
    int         cs_fall_t = 0;
    int         cs_rise_n = 0;

    assign miso = s_sh[7];

    always @(negedge cs_n) begin
        cs_fall_t = cyc;
        s_sh      = resp_mem[got_n & 15];
        s_cnt     = 0;
        s_started = 1'b0;
    end

    always @(posedge cs_n) cs_rise_n++;

    always @(sclk) begin
        if (cs_n === 1'b0) begin
            edge_t[edge_n & 63] = cyc;
            edge_n++;
            if (sclk != m_cpol) begin
                if (!m_cpha) s_in = mosi;
                else begin
                    if (s_started) s_sh = {s_sh[6:0], s_in};
                    s_started = 1'b1;
                end
            end else begin
                if (!m_cpha) begin
                    s_sh = {s_sh[6:0], s_in};
                    s_cnt++;
                    if (s_cnt == 8) begin
                        got[got_n & 15] = s_sh;
                        got_n++;
                        s_cnt = 0;
                        s_sh  = resp_mem[got_n & 15];
                    end
                end else begin
                    s_in = mosi;
                    s_cnt++;
                    if (s_cnt == 8) begin
                        got[got_n & 15] = {s_sh[6:0], s_in};
                        got_n++;
                        s_cnt     = 0;
                        s_started = 1'b0;
                        s_sh      = resp_mem[got_n & 15];
                    end
                end
            end
        end
    end

    // {cpol, cpha, div[7:0], tx[7:0], resp[7:0]}
    localparam logic [25:0] VEC [8] = '{
        {1'b0, 1'b0, 8'd0, 8'hA5, 8'h3C},
        {1'b0, 1'b1, 8'd1, 8'h5A, 8'hC3},
        {1'b1, 1'b0, 8'd2, 8'h81, 8'h7E},
        {1'b1, 1'b1, 8'd0, 8'hF0, 8'h0F},
        {1'b0, 1'b0, 8'd3, 8'h01, 8'h80},
        {1'b1, 1'b1, 8'd4, 8'h80, 8'h01},
        {1'b0, 1'b1, 8'd0, 8'hFF, 8'h00},
        {1'b1, 1'b0, 8'd1, 8'h00, 8'hFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [HOST_W-1:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [HOST_W-1:0] v);
        addr = a; rd_en = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        logic [HOST_W-1:0] s;
        repeat (2) @(negedge clk);
        do read_reg(A_STAT, s); while (s[S_BUSY] || !s[S_TXEMPTY]);
    endtask

    function automatic logic [HOST_W-1:0] cfg(input logic en, input logic ph,
                                              input logic po, input logic [7:0] n);
        return {en, ph, po, n};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [HOST_W-1:0] r;
        int base, base_e, base_r;
        for (int i = 0; i < 16; i++) resp_mem[i] = 8'h30 + 8'(i);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cs_n", 32'(cs_n), 32'h1);
        check("R1 sclk", 32'(sclk), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        read_reg(A_STAT, r);
        check("R1 status", 32'(r), 32'h00A);

        // table-driven exchanges across modes and dividers
        for (int i = 0; i < 8; i++) begin
            logic [25:0] v;
            v = VEC[i];
            m_cpol = v[25]; m_cpha = v[24];
            write_reg(A_CFG, cfg(1'b1, v[24], v[25], v[23:16]));
            repeat (2) @(negedge clk);
            check("R3 idle level", 32'(sclk), 32'(v[25]));
            base = got_n;
            resp_mem[base & 15] = v[7:0];
            write_reg(A_DATA, HOST_W'(v[15:8]));
            wait_idle();
            check("R2 R4 slave got byte", 32'(got[base & 15]), 32'(v[15:8]));
            check("R2 one byte", got_n - base, 1);
            read_reg(A_DATA, r);
            check("R2 R4 master got byte", 32'(r[7:0]), 32'(v[7:0]));
            check("R10 irq set", 32'(irq), 32'h1);
            write_reg(A_STAT, HOST_W'(1) << S_DONE);
            check("R10 irq cleared", 32'(irq), 32'h0);
        end

        // R5 R6: divider spacing and inter-byte gap
        m_cpol = 1'b0; m_cpha = 1'b0;
        write_reg(A_CFG, cfg(1'b0, 1'b0, 1'b0, 8'd2));
        base = got_n; base_e = edge_n; base_r = cs_rise_n;
        resp_mem[base & 15] = 8'h96; resp_mem[(base + 1) & 15] = 8'h69;
        write_reg(A_DATA, HOST_W'(8'h3C));
        write_reg(A_DATA, HOST_W'(8'hC3));
        wait_idle();
        check("R6 edge count", edge_n - base_e, 32);
        check("R5 first edge delay", edge_t[base_e & 63] - cs_fall_t, 3);
        check("R5 half period", edge_t[(base_e + 1) & 63] - edge_t[base_e & 63], 3);
        check("R6 gap", edge_t[(base_e + 16) & 63] - edge_t[(base_e + 15) & 63], 9);
        check("R6 R7 single cs release", cs_rise_n - base_r, 1);
        check("R7 cs_n high after", 32'(cs_n), 32'h1);
        check("R6 second byte", 32'(got[(base + 1) & 15]), 32'hC3);
        read_reg(A_DATA, r);
        check("R9 order first", 32'(r[7:0]), 32'h96);
        read_reg(A_DATA, r);
        check("R9 order second", 32'(r[7:0]), 32'h69);

        // R8 R9 R11: overflow of both queues, frozen config
        write_reg(A_CFG, cfg(1'b0, 1'b0, 1'b0, 8'd0));
        write_reg(A_STAT, HOST_W'(1) << S_DONE);
        base = got_n;
        for (int k = 0; k < 12; k++) resp_mem[(base + k) & 15] = 8'h40 + 8'(k);
        for (int k = 0; k < 12; k++) write_reg(A_DATA, HOST_W'(8'h10 + 8'(k)));
        read_reg(A_STAT, r);
        check("R8 tx full", 32'(r[S_TXFULL]), 32'h1);
        check("R8 collision set", 32'(r[S_COLL]), 32'h1);
        write_reg(A_CFG, cfg(1'b1, 1'b1, 1'b1, 8'd5));
        wait_idle();
        check("R8 accepted count", got_n - base, 9);
        check("R8 last accepted", 32'(got[(base + 8) & 15]), 32'h18);
        read_reg(A_CFG, r);
        check("R11 config unchanged", 32'(r), 32'h000);
        read_reg(A_STAT, r);
        check("R8 collision sticky", 32'(r[S_COLL]), 32'h1);
        check("R9 rx full", 32'(r[S_RXFULL]), 32'h1);
        write_reg(A_STAT, HOST_W'(1) << S_COLL);
        read_reg(A_STAT, r);
        check("R8 collision cleared", 32'(r[S_COLL]), 32'h0);
        for (int k = 0; k < 8; k++) begin
            read_reg(A_DATA, r);
            check("R9 rx data", 32'(r[7:0]), 32'(8'h40 + 8'(k)));
        end
        read_reg(A_STAT, r);
        check("R9 rx empty after 8", 32'(r[S_RXEMPTY]), 32'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule